// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits on the synchronous side of a chip and drives a 32K x 8 asynchronous static RAM. A client presents one read or write request per handshake. The controller turns it into a timed sequence of active-low chip-select, output-enable and write-strobe pulses on the memory pins, together with a 15-bit address and an 8-bit data bus. The data bus is split into an outgoing byte, an incoming byte and a local drive enable, so that a pad ring can build the bidirectional pin from them.

Each phase lasts a whole number of clock periods. The count is the memory's minimum time rounded up to the clock period, and a parameter picks the 35 ns or the 70 ns speed grade. Every access opens with a setup cycle in which the address settles while all strobes are inactive. The address never moves while a strobe is low. Writes are chip-select controlled, with output-enable held inactive, and the controller drives the bus only while the write strobe is low. A bus turnaround gap follows every access. A read hands its byte back with a one-cycle valid pulse, and `ready` is high only when the controller is idle.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1 (inactive), `sram_dq_oe` is 0, `rd_valid` is 0 and `ready` is 1.
- R2: `ready` is 1 only when the controller is idle, and all strobes are then inactive. A request presented while `ready` is 0 is ignored and never reaches the memory.
- R3: `sram_addr` changes only in a cycle in which both `sram_ce_n` and `sram_we_n` are 1, both before and after the change.
- R4: A read (`req_write` = 0) holds `sram_ce_n` = 0 and `sram_oe_n` = 0, with `sram_we_n` = 1, for RD = ceil(max access time / clock period) cycles. The access time is 35 ns fast and 70 ns slow. The data bus is sampled on the edge that ends this window. `rd_valid` is then 1 for exactly one cycle with the sampled byte on `rd_data`, two cycles plus RD after the request cycle.
- R5: A write (`req_write` = 1) is chip-select controlled. `sram_ce_n` and `sram_we_n` are 0 together for WP cycles, and `sram_oe_n` stays 1. WP is the largest of ceil(CE-to-end / Tclk), ceil(write pulse / Tclk), ceil((write-to-high-Z + data setup) / Tclk) and ceil(cycle time / Tclk) - 1. With a 20 ns clock this gives 2 cycles fast and 3 cycles slow.
- R6: `sram_dq_oe` is 1 exactly while `sram_we_n` is 0. It rises and falls on the same edges as the write strobe. Throughout that window `sram_dq_out` carries the request's write byte.
- R7: After acceptance there is one setup cycle in which the new address is present and all strobes are 1. After an access there are TA = ceil(max(chip-disable-to-high-Z, output-disable-to-high-Z) / Tclk) idle cycles before `ready` returns. These times are 25 ns fast and 35 ns slow. `ready` is seen again RD+TA+2 cycles after a read request and WP+TA+2 cycles after a write request.
- R8: `FAST` = 0 selects the slow grade. With a 20 ns clock this gives RD = 4, WP = 3 and TA = 2. `FAST` = 1 gives RD = 2, WP = 2 and TA = 2.
- R9: A read returns the byte most recently written to that address, for any address including 0x0000 and 0x7FFF and any data value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Idle, able to accept a request |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| rd_data | output | 8 | Byte returned by a read |
| sram_addr | output | 15 | Memory address pins |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_dq_out | output | 8 | Byte driven onto the data bus |
| sram_dq_in | input | 8 | Byte read from the data bus |
| sram_dq_oe | output | 1 | Local data-bus drive enable |

## Verification
The assertions check the following on every cycle:
- The address does not move while a strobe is low.
- Output-enable and write strobe are never low together.
- The local drive enable coincides with the write strobe.
- Idle implies that all strobes are inactive.
- The valid pulse lasts one cycle.
- The strobe-low windows have the lengths RD and WP set by the grade.

Only the bench's scenarios, run against a memory model that returns unsettled data until the access time has elapsed, can show:
- that data is sampled late enough;
- that bytes survive a write and read-back at extreme addresses;
- that a request made while busy is lost;
- that the slow grade stretches the windows.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ,
    ST_WRITE,
    ST_RECOV
  } seq_state_t;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Read window: the largest of address, chip-select and output-enable access
  function automatic int unsigned read_cycles(input bit fast, input int unsigned clk_ns);
    int unsigned acc_ns;
    int unsigned oe_ns;
    acc_ns = fast ? 35 : 70;
    oe_ns  = fast ? 25 : 35;
    return ns_to_cyc(max_u(acc_ns, oe_ns), clk_ns);
  endfunction

  // Write window: strobe overlap covers CE-to-end, pulse width, high-Z plus data setup,
  // and together with the setup cycle the whole write cycle
  function automatic int unsigned write_cycles(input bit fast, input int unsigned clk_ns);
    int unsigned ce_end_ns;
    int unsigned pulse_ns;
    int unsigned hiz_dat_ns;
    int unsigned cyc_ns;
    int unsigned w;
    int unsigned wc;
    ce_end_ns  = fast ? 30 : 60;
    pulse_ns   = fast ? 25 : 50;
    hiz_dat_ns = fast ? (15 + 20) : (25 + 30);
    cyc_ns     = fast ? 35 : 70;
    w  = ns_to_cyc(max_u(max_u(ce_end_ns, pulse_ns), hiz_dat_ns), clk_ns);
    wc = ns_to_cyc(cyc_ns, clk_ns);
    return (wc > 1) ? max_u(w, wc - 1) : w;
  endfunction

  // Turnaround: memory drivers must be off before the next access
  function automatic int unsigned turn_cycles(input bit fast, input int unsigned clk_ns);
    return ns_to_cyc(fast ? 25 : 35, clk_ns);
  endfunction

endpackage

// File: rtl/sram_ctl_timing.sv
module sram_ctl_timing
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_NS = 20,
  parameter bit          FAST   = 1'b1,
  parameter int unsigned CNT_W  = 8
) (
  output logic [CNT_W-1:0] rd_len,
  output logic [CNT_W-1:0] wr_len,
  output logic [CNT_W-1:0] ta_len
);

  generate
    if (FAST) begin : g_fast
      assign rd_len = CNT_W'(read_cycles(1'b1, CLK_NS));
      assign wr_len = CNT_W'(write_cycles(1'b1, CLK_NS));
      assign ta_len = CNT_W'(turn_cycles(1'b1, CLK_NS));
    end else begin : g_slow
      assign rd_len = CNT_W'(read_cycles(1'b0, CLK_NS));
      assign wr_len = CNT_W'(write_cycles(1'b0, CLK_NS));
      assign ta_len = CNT_W'(turn_cycles(1'b0, CLK_NS));
    end
  endgenerate

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CNT_W-1:0] rd_len,
  input  logic [CNT_W-1:0] wr_len,
  input  logic [CNT_W-1:0] ta_len,
  output logic             ready,
  output logic             accept,
  output logic             capture,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe
);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic             last_beat;

  assign ready     = (state_q == ST_IDLE);
  assign accept    = ready & req_valid;
  assign last_beat = (cnt_q == '0);
  assign capture   = (state_q == ST_READ) & last_beat;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SETUP;
          wr_d    = req_write;
        end
      end
      ST_SETUP: begin
        state_d = wr_q ? ST_WRITE : ST_READ;
        cnt_d   = wr_q ? (wr_len - 1'b1) : (rd_len - 1'b1);
      end
      ST_READ, ST_WRITE: begin
        if (last_beat) begin
          state_d = ST_RECOV;
          cnt_d   = ta_len - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RECOV: begin
        if (last_beat) state_d = ST_IDLE;
        else           cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      ce_n    <= !((state_d == ST_READ) || (state_d == ST_WRITE));
      oe_n    <= !(state_d == ST_READ);
      we_n    <= !(state_d == ST_WRITE);
      dq_oe   <= (state_d == ST_WRITE);
    end
  end

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr     <= '0;
      dq_out   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (accept) begin
        addr   <= req_addr;
        dq_out <= req_wdata;
      end
      rd_valid <= capture;
      if (capture) rd_data <= dq_in;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CLK_NS = 20,
  parameter bit          FAST   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);

  localparam int unsigned CNT_W = 8;

  logic [CNT_W-1:0] rd_len, wr_len, ta_len;
  logic             accept, capture;

  sram_ctl_timing #(.CLK_NS(CLK_NS), .FAST(FAST), .CNT_W(CNT_W)) u_timing (
    .rd_len (rd_len),
    .wr_len (wr_len),
    .ta_len (ta_len)
  );

  sram_ctl_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rd_len    (rd_len),
    .wr_len    (wr_len),
    .ta_len    (ta_len),
    .ready     (ready),
    .accept    (accept),
    .capture   (capture),
    .ce_n      (sram_ce_n),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n),
    .dq_oe     (sram_dq_oe)
  );

  sram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (sram_dq_in),
    .addr      (sram_addr),
    .dq_out    (sram_dq_out),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned CLK_NS = 20,
  parameter bit          FAST   = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe
);

  localparam int unsigned RD_LEN = read_cycles(FAST, CLK_NS);
  localparam int unsigned WR_LEN = write_cycles(FAST, CLK_NS);

  logic [7:0] low_cnt;
  logic       saw_wr;
  logic       in_rst_q;

  always_ff @(posedge clk) begin
    in_rst_q <= !rst_n;
    if (!rst_n) begin
      low_cnt <= '0;
      saw_wr  <= 1'b0;
    end else if (!sram_ce_n) begin
      low_cnt <= low_cnt + 1'b1;
      saw_wr  <= !sram_we_n;
    end else begin
      low_cnt <= '0;
      saw_wr  <= 1'b0;
    end
  end

  // R1: strobes inactive and bus released after a reset edge
  always @(negedge clk) begin
    if (in_rst_q === 1'b1) begin
      a_r1_reset_idle: assert (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rd_valid && ready);
    end
  end

  a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n || !sram_we_n) |=> $stable(sram_addr));

  a_r4_read_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_ce_n && sram_we_n));

  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r4_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(sram_oe_n));

  // R4 and R8: read window length for the selected grade
  a_r4_read_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sram_ce_n) && !saw_wr) |-> (low_cnt == 8'(RD_LEN)));

  a_r5_write_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n));

  // R5 and R8: write window length for the selected grade
  a_r5_write_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sram_ce_n) && saw_wr) |-> (low_cnt == 8'(WR_LEN)));

  a_r6_drive_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (!sram_we_n && sram_oe_n));

  a_r6_drive_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> $fell(sram_dq_oe));

  a_r7_setup_before_select: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_ce_n) |-> $stable(sram_addr));

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .FAST(FAST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .rd_valid   (rd_valid),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_ctl_tb.sv
module sram_model #(
  parameter int CLK_NS = 20,
  parameter int T_ACC  = 35
) (
  input  logic        clk,
  input  logic [14:0] addr,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [7:0]  dq_w,
  input  logic        dq_oe,
  output logic [7:0]  dq_r,
  output int          rd_low,
  output int          wr_low,
  output int          viol
);
  logic [7:0]  mem [logic [14:0]];
  logic [14:0] addr_prev;
  logic        wr_prev, strobe_prev, was_wr;
  logic [7:0]  hold;
  int          cnt;

  initial begin
    rd_low = 0; wr_low = 0; viol = 0; cnt = 0;
    addr_prev = '0; wr_prev = 0; strobe_prev = 0; was_wr = 0; hold = '0; dq_r = 8'hEE;
  end

  always @(negedge clk) begin
    logic strobe_now, wr_now;
    strobe_now = (ce_n === 1'b0) || (we_n === 1'b0);
    wr_now     = (ce_n === 1'b0) && (we_n === 1'b0);
    if ((addr !== addr_prev) && (strobe_now || strobe_prev)) viol++;
    if ((dq_oe === 1'b1) && ((oe_n !== 1'b1) || (we_n !== 1'b0))) viol++;
    if (wr_now) begin
      if (dq_oe === 1'b1) hold = dq_w;
      else viol++;
      was_wr = 1'b1;
    end
    if (wr_prev && !wr_now) mem[addr] = hold;
    if (ce_n === 1'b0) cnt++;
    else if (cnt != 0) begin
      if (was_wr) wr_low = cnt;
      else        rd_low = cnt;
      cnt = 0;
      was_wr = 1'b0;
    end
    if ((ce_n === 1'b0) && (oe_n === 1'b0) && (we_n === 1'b1) && (cnt * CLK_NS >= T_ACC))
      dq_r = mem.exists(addr) ? mem[addr] : 8'h00;
    else
      dq_r = 8'hEE;
    addr_prev   = addr;
    wr_prev     = wr_now;
    strobe_prev = strobe_now;
  end
endmodule

module sram_ctl_tb;
  localparam int TCLK = 20;

  function automatic int cyc(input int ns);
    return (ns + TCLK - 1) / TCLK;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int F_RD = 2, F_WP = 2, F_TA = 2;
  localparam int S_RD = 4, S_WP = 3, S_TA = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(TCLK/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // fast instance
  logic        req_valid = 0, req_write = 0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, rd_valid, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0]  rd_data, sram_dq_out, sram_dq_in;
  logic [14:0] sram_addr;
  int          f_rd_low, f_wr_low, f_viol;

  sram_ctl #(.CLK_NS(TCLK), .FAST(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
    .sram_dq_oe(sram_dq_oe));

  sram_model #(.CLK_NS(TCLK), .T_ACC(35)) u_mem_f (
    .clk(clk), .addr(sram_addr), .ce_n(sram_ce_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
    .dq_w(sram_dq_out), .dq_oe(sram_dq_oe), .dq_r(sram_dq_in),
    .rd_low(f_rd_low), .wr_low(f_wr_low), .viol(f_viol));

  // slow instance
  logic        s_req_valid = 0, s_req_write = 0;
  logic [14:0] s_req_addr = '0;
  logic [7:0]  s_req_wdata = '0;
  logic        s_ready, s_rd_valid, s_ce_n, s_oe_n, s_we_n, s_dq_oe;
  logic [7:0]  s_rd_data, s_dq_out, s_dq_in;
  logic [14:0] s_addr;
  int          s_rd_low, s_wr_low, s_viol;

  sram_ctl #(.CLK_NS(TCLK), .FAST(1'b0)) u_slow (
    .clk(clk), .rst_n(rst_n), .req_valid(s_req_valid), .req_write(s_req_write),
    .req_addr(s_req_addr), .req_wdata(s_req_wdata), .ready(s_ready), .rd_valid(s_rd_valid),
    .rd_data(s_rd_data), .sram_addr(s_addr), .sram_ce_n(s_ce_n), .sram_oe_n(s_oe_n),
    .sram_we_n(s_we_n), .sram_dq_out(s_dq_out), .sram_dq_in(s_dq_in), .sram_dq_oe(s_dq_oe));

  sram_model #(.CLK_NS(TCLK), .T_ACC(70)) u_mem_s (
    .clk(clk), .addr(s_addr), .ce_n(s_ce_n), .oe_n(s_oe_n), .we_n(s_we_n),
    .dq_w(s_dq_out), .dq_oe(s_dq_oe), .dq_r(s_dq_in),
    .rd_low(s_rd_low), .wr_low(s_wr_low), .viol(s_viol));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d, output int rlat, output int werr);
    int n;
    wait_ready();
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    n = 0; rlat = 0; werr = 0;
    while (rlat == 0 && n < 60) begin
      @(negedge clk);
      n++;
      req_valid = 0;
      if (n == 1) begin
        if (!(sram_ce_n && sram_oe_n && sram_we_n) || sram_addr !== a) werr += 100;
      end
      if (sram_dq_oe !== !sram_we_n) werr++;
      if (!sram_we_n && sram_dq_out !== d) werr++;
      if (ready) rlat = n;
    end
  endtask

  task automatic do_read(input logic [14:0] a, output logic [7:0] data, output int vlat,
                         output int rlat, output int perr);
    int n;
    wait_ready();
    req_valid = 1; req_write = 0; req_addr = a;
    n = 0; rlat = 0; vlat = 0; perr = 0; data = '0;
    while (rlat == 0 && n < 60) begin
      @(negedge clk);
      n++;
      req_valid = 0;
      if (rd_valid) begin
        if (vlat == 0) begin vlat = n; data = rd_data; end
        else perr++;
      end
      if (ready) rlat = n;
    end
  endtask

  task automatic t_reset();
    check(sram_ce_n === 1'b1, "R1 ce_n", int'(sram_ce_n), 1);
    check(sram_oe_n === 1'b1, "R1 oe_n", int'(sram_oe_n), 1);
    check(sram_we_n === 1'b1, "R1 we_n", int'(sram_we_n), 1);
    check(sram_dq_oe === 1'b0, "R1 dq_oe", int'(sram_dq_oe), 0);
    check(rd_valid === 1'b0 && ready === 1'b1, "R1 rd_valid/ready", int'({rd_valid, ready}), 1);
  endtask

  task automatic t_write_read();
    int rl, we, vl, pe;
    logic [7:0] d;
    do_write(15'h0012, 8'h5A, rl, we);
    check(rl == F_WP + F_TA + 2, "R7 write ready latency", rl, F_WP + F_TA + 2);
    check(we < 100, "R7 setup cycle strobes/address", we, 0);
    check(we == 0, "R6 drive window and write byte", we, 0);
    check(f_wr_low == F_WP, "R5 write strobe window", f_wr_low, F_WP);
    do_read(15'h0012, d, vl, rl, pe);
    check(d == 8'h5A, "R4 read data", int'(d), 8'h5A);
    check(vl == F_RD + 2, "R4 valid latency", vl, F_RD + 2);
    check(pe == 0, "R4 single valid pulse", pe, 0);
    check(f_rd_low == F_RD, "R4 read strobe window", f_rd_low, F_RD);
    check(rl == F_RD + F_TA + 2, "R7 read ready latency", rl, F_RD + F_TA + 2);
  endtask

  task automatic t_patterns();
    int rl, we, vl, pe;
    logic [7:0] d;
    do_write(15'h0000, 8'hFF, rl, we);
    do_write(15'h7FFF, 8'h00, rl, we);
    do_write(15'h2A55, 8'hC3, rl, we);
    do_write(15'h0000, 8'h81, rl, we);
    do_read(15'h7FFF, d, vl, rl, pe);
    check(d == 8'h00, "R9 top address", int'(d), 8'h00);
    do_read(15'h2A55, d, vl, rl, pe);
    check(d == 8'hC3, "R9 mid address", int'(d), 8'hC3);
    do_read(15'h0000, d, vl, rl, pe);
    check(d == 8'h81, "R9 overwritten address 0", int'(d), 8'h81);
    check(f_viol == 0, "R3 address moved under strobe", f_viol, 0);
  endtask

  task automatic t_busy_ignore();
    int vl, rl, pe;
    logic [7:0] d;
    wait_ready();
    req_valid = 1; req_write = 1; req_addr = 15'h0100; req_wdata = 8'h11;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 15'h0200; req_wdata = 8'h22;
    check(ready === 1'b0, "R2 ready low while busy", int'(ready), 0);
    @(negedge clk);
    req_valid = 0;
    do_read(15'h0200, d, vl, rl, pe);
    check(d == 8'h00, "R2 busy request ignored", int'(d), 8'h00);
    do_read(15'h0100, d, vl, rl, pe);
    check(d == 8'h11, "R2 accepted request written", int'(d), 8'h11);
  endtask

  task automatic t_slow_grade();
    int n, rl;
    logic [7:0] d;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_req_valid = 1; s_req_write = 1; s_req_addr = 15'h3333; s_req_wdata = 8'hA7;
    n = 0; rl = 0;
    while (rl == 0 && n < 60) begin
      @(negedge clk); n++; s_req_valid = 0;
      if (s_ready) rl = n;
    end
    check(rl == S_WP + S_TA + 2, "R8 slow write ready latency", rl, S_WP + S_TA + 2);
    check(s_wr_low == mx(mx(cyc(60), cyc(55)), cyc(70) - 1), "R8 slow write window", s_wr_low, S_WP);
    s_req_valid = 1; s_req_write = 0; s_req_addr = 15'h3333;
    n = 0; rl = 0; d = '0;
    while (rl == 0 && n < 60) begin
      @(negedge clk); n++; s_req_valid = 0;
      if (s_rd_valid) d = s_rd_data;
      if (s_ready) rl = n;
    end
    check(s_rd_low == cyc(70), "R8 slow read window", s_rd_low, S_RD);
    check(d == 8'hA7, "R8 slow read data", int'(d), 8'hA7);
    check(rl == S_RD + S_TA + 2, "R8 slow read ready latency", rl, S_RD + S_TA + 2);
    check(s_viol == 0, "R3 slow address moved under strobe", s_viol, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_patterns();
    t_busy_ignore();
    t_slow_grade();
    check(f_viol == 0, "R6 bus driven outside write window", f_viol, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule